// File: doc/BRIEF.md
# Power-Management Event Status and System Control Interrupt

This block holds the power-management event status and event enable registers and drives the level-sensitive System Control Interrupt (SCI) from them. Software reaches both registers through a 64-byte I/O window. The window's base address and its decode enable are supplied by configuration logic outside the block. Four hardware event sources set latched status bits with a one-cycle pulse: timer overflow, global lock release, power button and real-time-clock alarm. Software clears a status bit by writing a one to it.

The SCI output is high while at least one of the four event sources has both its status bit and its enable bit set. The output is computed directly from the registers, so it follows every register update in the same cycle that the update becomes visible. Word accesses at the two defined offsets reach the registers. Every other access that falls in the window is claimed, reads back zero and changes nothing.

Top module: `pm_event_sci`

## Requirements
- R1: After reset the status and enable registers read 0x0000 and `sci_o` is low.
- R2: An access is claimed (`io_claim_o` high) only while `cfg_win_en_i` is 1, a read or write strobe is active, and `io_addr_i[15:6]` equals `cfg_base_i[15:6]`. Bits 5:0 of the base and bits 31:16 of the configuration dword have no effect.
- R3: Inside the window only `io_addr_i[3:0]` selects the register. 0x0 selects status and 0x2 selects enable, so bits 5:4 alias (0x10 reaches status, 0x22 reaches enable).
- R4: A one-cycle pulse on an event input sets its status bit at the next clock edge. The bit positions are timer 0, global lock 5, power button 8 and RTC alarm 10.
- R5: A word write to the status register clears each implemented bit written as one. Bits written as zero keep their value.
- R6: When an event pulse and a clearing write hit the same status bit in the same cycle, the bit ends up set.
- R7: The enable register is a 16-bit read/write register. A word write stores all 16 bits, and a word read returns them.
- R8: `sci_o` equals the OR over bits 0, 5, 8 and 10 of (status AND enable). It reflects a register update in the cycle right after the clock edge that made the update.
- R9: Word accesses to offsets other than 0x0 and 0x2, and all accesses with `io_wide_i` high, read zero and leave both registers unchanged.
- R10: Status bits other than 0, 5, 8 and 10 always read as zero.
- R11: Accesses that are not claimed read zero and change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_base_i | input | 32 | Configuration dword holding the window base; only bits 15:6 are used |
| cfg_win_en_i | input | 1 | Window decode enable from configuration |
| io_addr_i | input | 16 | I/O address |
| io_rd_i | input | 1 | Read strobe |
| io_wr_i | input | 1 | Write strobe |
| io_wide_i | input | 1 | 1 = 32-bit access, 0 = 16-bit access |
| io_wdata_i | input | 16 | Write data |
| io_rdata_o | output | 16 | Read data, valid in the strobe cycle |
| io_claim_o | output | 1 | Access falls inside the enabled window |
| evt_tmr_i | input | 1 | Timer overflow event pulse |
| evt_gbl_i | input | 1 | Global lock release event pulse |
| evt_pwr_i | input | 1 | Power button event pulse |
| evt_rtc_i | input | 1 | RTC alarm event pulse |
| sci_o | output | 1 | System Control Interrupt level |

## Verification
The bench drives an event and a clearing write at the same bit in the same cycle. A design that let the clear win would lose an interrupt and leave the SCI low. It writes to alias offsets (0x10, 0x22) and to a window base whose low six bits are non-zero. Decoding too many address bits would miss those accesses, and using the base's low bits would move the window. Wide accesses, unused word offsets and all-ones writes to status are also applied. A design that decoded access size loosely, or stored unimplemented status bits, would show non-zero reads or a spurious SCI. Finally, turning off the enable or the window checks that the SCI drops exactly one cycle after the enable write, and that accesses made while the window is off do nothing.

// File: rtl/pm_evt_pkg.sv
package pm_evt_pkg;
  localparam int unsigned PM_W = 16;
  localparam int unsigned NSRC = 4;

  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_STS  = 2'd1,
    SEL_EN   = 2'd2
  } pm_sel_e;

  // Status bit position for each event source: timer, global lock, power button, RTC.
  function automatic int unsigned src_bit(input int unsigned idx);
    case (idx)
      0:       return 0;
      1:       return 5;
      2:       return 8;
      default: return 10;
    endcase
  endfunction

  function automatic logic [PM_W-1:0] src_mask();
    logic [PM_W-1:0] m;
    m = '0;
    for (int unsigned i = 0; i < NSRC; i++) m[src_bit(i)] = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/pm_win_decode.sv
module pm_win_decode
  import pm_evt_pkg::*;
#(
  parameter int unsigned ADDR_W  = 16,
  parameter int unsigned WIN_LSB = 6,
  parameter int unsigned OFF_W   = 4
) (
  input  logic [ADDR_W-1:0]       addr_i,
  input  logic [ADDR_W-WIN_LSB-1:0] base_hi_i,
  input  logic                    win_en_i,
  input  logic                    rd_i,
  input  logic                    wr_i,
  input  logic                    wide_i,
  output logic                    claim_o,
  output logic                    rd_sts_o,
  output logic                    rd_en_o,
  output logic                    wr_sts_o,
  output logic                    wr_en_o
);
  localparam logic [OFF_W-1:0] OFF_STS = OFF_W'(0);
  localparam logic [OFF_W-1:0] OFF_EN  = OFF_W'(2);

  logic    hit;
  pm_sel_e sel;
  logic    unused_addr_bits;

  assign unused_addr_bits = ^addr_i[WIN_LSB-1:OFF_W];

  always_comb begin
    hit     = win_en_i && (addr_i[ADDR_W-1:WIN_LSB] == base_hi_i);
    claim_o = hit && (rd_i || wr_i);
    sel     = SEL_NONE;
    if (!wide_i) begin
      if (addr_i[OFF_W-1:0] == OFF_STS)     sel = SEL_STS;
      else if (addr_i[OFF_W-1:0] == OFF_EN) sel = SEL_EN;
    end
    rd_sts_o = claim_o && rd_i && (sel == SEL_STS);
    rd_en_o  = claim_o && rd_i && (sel == SEL_EN);
    wr_sts_o = claim_o && wr_i && (sel == SEL_STS);
    wr_en_o  = claim_o && wr_i && (sel == SEL_EN);
  end
endmodule

// File: rtl/pm_evt_regs.sv
module pm_evt_regs
  import pm_evt_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] evt_i,
  input  logic            wr_sts_i,
  input  logic            wr_en_i,
  input  logic            rd_sts_i,
  input  logic            rd_en_i,
  input  logic [PM_W-1:0] wdata_i,
  output logic [PM_W-1:0] sts_o,
  output logic [PM_W-1:0] en_o,
  output logic [PM_W-1:0] rdata_o
);
  logic [PM_W-1:0] sts_q, sts_d;
  logic [PM_W-1:0] en_q, en_d;
  logic            sts_ce, en_ce;

  // Next state: clear on write-one, then event set dominates.
  always_comb begin
    sts_d  = '0;
    for (int unsigned i = 0; i < NSRC; i++) begin
      sts_d[src_bit(i)] = evt_i[i] ||
                          (sts_q[src_bit(i)] && !(wr_sts_i && wdata_i[src_bit(i)]));
    end
    sts_ce = wr_sts_i || (|evt_i);
    en_d   = wdata_i;
    en_ce  = wr_en_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      sts_q <= '0;
    else if (sts_ce) sts_q <= sts_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     en_q <= '0;
    else if (en_ce) en_q <= en_d;
  end

  always_comb begin
    rdata_o = '0;
    if (rd_sts_i)     rdata_o = sts_q;
    else if (rd_en_i) rdata_o = en_q;
  end

  assign sts_o = sts_q;
  assign en_o  = en_q;

  for (genvar g = 0; g < NSRC; g++) begin : g_chk
    // R4: an event pulse sets its status bit
    a_r4_evt_sets: assert property (@(posedge clk) disable iff (!rst_n)
      evt_i[g] |=> sts_q[src_bit(g)]);
    // R5: a one written without a competing event clears the bit
    a_r5_w1c: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_sts_i && wdata_i[src_bit(g)] && !evt_i[g]) |=> !sts_q[src_bit(g)]);
  end

  // R7: enable write stores the full word
  a_r7_en_store: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_i |=> (en_q == $past(wdata_i)));
endmodule

// File: rtl/pm_sci_gen.sv
module pm_sci_gen
  import pm_evt_pkg::*;
(
  input  logic [PM_W-1:0] sts_i,
  input  logic [PM_W-1:0] en_i,
  output logic            sci_o
);
  localparam logic [PM_W-1:0] SCI_MASK = src_mask();

  assign sci_o = |(sts_i & en_i & SCI_MASK);
endmodule

// File: rtl/pm_event_sci.sv
module pm_event_sci
  import pm_evt_pkg::*;
#(
  parameter int unsigned ADDR_W  = 16,
  parameter int unsigned CFG_W   = 32,
  parameter int unsigned WIN_LSB = 6,
  parameter int unsigned OFF_W   = 4,
  parameter int unsigned SYNC_N  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CFG_W-1:0]  cfg_base_i,
  input  logic              cfg_win_en_i,
  input  logic [ADDR_W-1:0] io_addr_i,
  input  logic              io_rd_i,
  input  logic              io_wr_i,
  input  logic              io_wide_i,
  input  logic [PM_W-1:0]   io_wdata_i,
  output logic [PM_W-1:0]   io_rdata_o,
  output logic              io_claim_o,
  input  logic              evt_tmr_i,
  input  logic              evt_gbl_i,
  input  logic              evt_pwr_i,
  input  logic              evt_rtc_i,
  output logic              sci_o
);
  logic [SYNC_N-1:0] rst_pipe;
  logic              rst_int_n;
  logic              rd_sts, rd_en, wr_sts, wr_en;
  logic [PM_W-1:0]   sts, en;
  logic [NSRC-1:0]   evt;
  logic              unused_cfg_bits;

  assign unused_cfg_bits = ^{cfg_base_i[CFG_W-1:ADDR_W], cfg_base_i[WIN_LSB-1:0]};

  // Asynchronous assertion, synchronous release.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[SYNC_N-2:0], 1'b1};
  end
  assign rst_int_n = rst_pipe[SYNC_N-1];

  assign evt = {evt_rtc_i, evt_pwr_i, evt_gbl_i, evt_tmr_i};

  pm_win_decode #(
    .ADDR_W (ADDR_W),
    .WIN_LSB(WIN_LSB),
    .OFF_W  (OFF_W)
  ) u_dec (
    .addr_i   (io_addr_i),
    .base_hi_i(cfg_base_i[ADDR_W-1:WIN_LSB]),
    .win_en_i (cfg_win_en_i),
    .rd_i     (io_rd_i),
    .wr_i     (io_wr_i),
    .wide_i   (io_wide_i),
    .claim_o  (io_claim_o),
    .rd_sts_o (rd_sts),
    .rd_en_o  (rd_en),
    .wr_sts_o (wr_sts),
    .wr_en_o  (wr_en)
  );

  pm_evt_regs u_regs (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .evt_i   (evt),
    .wr_sts_i(wr_sts),
    .wr_en_i (wr_en),
    .rd_sts_i(rd_sts),
    .rd_en_i (rd_en),
    .wdata_i (io_wdata_i),
    .sts_o   (sts),
    .en_o    (en),
    .rdata_o (io_rdata_o)
  );

  pm_sci_gen u_sci (
    .sts_i(sts),
    .en_i (en),
    .sci_o(sci_o)
  );

  // R8: SCI can only rise after an event or an enable write
  a_r8_sci_cause: assert property (@(posedge clk) disable iff (!rst_int_n)
    $rose(sci_o) |-> $past((|evt) || wr_en));
  // R11: nothing is claimed while the window is off
  a_r11_off_no_claim: assert property (@(posedge clk) disable iff (!rst_int_n)
    !cfg_win_en_i |-> !io_claim_o);
  // R9: wide reads return zero
  a_r9_wide_zero: assert property (@(posedge clk) disable iff (!rst_int_n)
    (io_rd_i && io_wide_i) |-> (io_rdata_o == '0));
  // R10: unimplemented status bits never read back
  a_r10_unimpl: assert property (@(posedge clk) disable iff (!rst_int_n)
    rd_sts |-> ((io_rdata_o & ~src_mask()) == '0));
endmodule

// File: tb/pm_event_sci_tb.sv
`timescale 1ns/1ps
module pm_event_sci_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] cfg_base = '0;
  logic        cfg_en = 1'b0;
  logic [15:0] io_addr = '0;
  logic        io_rd = 1'b0, io_wr = 1'b0, io_wide = 1'b0;
  logic [15:0] io_wdata = '0;
  logic [15:0] io_rdata;
  logic        io_claim;
  logic [3:0]  evt = '0;
  logic        sci;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  int unsigned m_sts = 0, m_en = 0;

  always #2 clk = ~clk;

  pm_event_sci u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_base_i(cfg_base), .cfg_win_en_i(cfg_en),
    .io_addr_i(io_addr), .io_rd_i(io_rd), .io_wr_i(io_wr), .io_wide_i(io_wide),
    .io_wdata_i(io_wdata), .io_rdata_o(io_rdata), .io_claim_o(io_claim),
    .evt_tmr_i(evt[0]), .evt_gbl_i(evt[1]), .evt_pwr_i(evt[2]), .evt_rtc_i(evt[3]),
    .sci_o(sci)
  );

  function automatic bit in_win();
    return cfg_en && ((io_addr & 16'hFFC0) == (cfg_base[15:0] & 16'hFFC0));
  endfunction

  // Behavioural reference: clear first, events afterwards so they dominate.
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_sts = 0; m_en = 0;
    end else begin
      if (in_win() && io_wr && !io_wide) begin
        if ((io_addr & 16'h000F) == 16'h0)      m_sts = m_sts & ~io_wdata;
        else if ((io_addr & 16'h000F) == 16'h2) m_en  = io_wdata;
      end
      if (evt[0]) m_sts = m_sts | 32'h0001;
      if (evt[1]) m_sts = m_sts | 32'h0020;
      if (evt[2]) m_sts = m_sts | 32'h0100;
      if (evt[3]) m_sts = m_sts | 32'h0400;
      m_sts = m_sts & 32'h0521;
    end
  end

  task automatic check(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic step(input logic [15:0] a, input logic r, input logic w, input logic wd,
                      input logic [15:0] d, input logic [3:0] e, input string tag);
    int exp_rd;
    @(negedge clk);
    io_addr = a; io_rd = r; io_wr = w; io_wide = wd; io_wdata = d; evt = e;
    #1;
    exp_rd = 0;
    if (in_win() && r && !wd) begin
      if ((a & 16'h000F) == 16'h0)      exp_rd = int'(m_sts);
      else if ((a & 16'h000F) == 16'h2) exp_rd = int'(m_en);
    end
    check(tag, "rdata", int'(io_rdata), exp_rd);
    check(tag, "claim", int'(io_claim), int'(in_win() && (r || w)));
    check(tag, "sci", int'(sci), int'((m_sts & m_en & 32'h0521) != 0));
  endtask

  task automatic idle(input string tag);
    step(16'h0000, 0, 0, 0, 16'h0, 4'h0, tag);
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) idle("R1");
    cfg_base = 32'hABCD_B03F;   // window at 0xB000, low bits and upper half ignored
    cfg_en   = 1'b1;
    step(16'hB000, 1, 0, 0, 0, 0, "R1");      // status after reset
    step(16'hB002, 1, 0, 0, 0, 0, "R1");      // enable after reset
    // R7: enable read/write
    step(16'hB002, 0, 1, 0, 16'hFFFF, 0, "R7");
    step(16'hB002, 1, 0, 0, 0, 0, "R7");
    // R4/R8: each event sets its bit and raises SCI
    step(16'h0000, 0, 0, 0, 0, 4'b0001, "R4");
    step(16'hB000, 1, 0, 0, 0, 0, "R4");
    step(16'h0000, 0, 0, 0, 0, 4'b0010, "R4");
    step(16'h0000, 0, 0, 0, 0, 4'b0100, "R4");
    step(16'h0000, 0, 0, 0, 0, 4'b1000, "R8");
    step(16'hB000, 1, 0, 0, 0, 0, "R4");
    // R5: clear timer only
    step(16'hB000, 0, 1, 0, 16'h0001, 0, "R5");
    step(16'hB000, 1, 0, 0, 0, 0, "R5");
    // R10: all-ones write leaves only real bits, then all clear
    step(16'hB000, 0, 1, 0, 16'hFFFF, 0, "R10");
    step(16'hB000, 1, 0, 0, 0, 0, "R10");
    idle("R8");
    // R6: event and clear in same cycle on power button
    step(16'hB000, 0, 1, 0, 16'h0100, 4'b0100, "R6");
    step(16'hB000, 1, 0, 0, 0, 0, "R6");
    // R8: SCI masked by enable bits
    step(16'hB002, 0, 1, 0, 16'hFEFF, 0, "R8");
    idle("R8");
    step(16'hB002, 0, 1, 0, 16'h0100, 0, "R8");
    idle("R8");
    step(16'hB002, 0, 1, 0, 16'h0000, 0, "R8");
    idle("R8");
    // R3/R2: aliased offsets 0x10 and 0x22
    step(16'hB010, 1, 0, 0, 0, 0, "R3");
    step(16'hB010, 0, 1, 0, 16'hFFFF, 4'b1000, "R3");
    step(16'hB022, 0, 1, 0, 16'h0400, 0, "R2");
    step(16'hB032, 1, 0, 0, 0, 0, "R2");
    // R9: other offsets and wide accesses
    step(16'hB004, 0, 1, 0, 16'h0000, 0, "R9");
    step(16'hB002, 0, 1, 1, 16'h0000, 0, "R9");
    step(16'hB000, 0, 1, 1, 16'hFFFF, 0, "R9");
    step(16'hB000, 1, 0, 1, 0, 0, "R9");
    step(16'hB002, 1, 0, 1, 0, 0, "R9");
    step(16'hB006, 1, 0, 0, 0, 0, "R9");
    step(16'hB002, 1, 0, 0, 0, 0, "R9");
    step(16'hB000, 1, 0, 0, 0, 0, "R9");
    // R11: outside window and window disabled
    step(16'hB040, 0, 1, 0, 16'h0000, 0, "R11");
    step(16'hB040, 1, 0, 0, 0, 0, "R11");
    step(16'h3000, 0, 1, 0, 16'hFFFF, 0, "R11");
    cfg_en = 1'b0;
    step(16'hB002, 0, 1, 0, 16'h0000, 0, "R11");
    step(16'hB000, 0, 1, 0, 16'hFFFF, 0, "R11");
    step(16'hB002, 1, 0, 0, 0, 0, "R11");
    cfg_en = 1'b1;
    step(16'hB002, 1, 0, 0, 0, 0, "R11");
    step(16'hB000, 1, 0, 0, 0, 0, "R11");
    step(16'hB000, 0, 1, 0, 16'h0400, 0, "R5");
    idle("R8");
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule